// File: doc/BRIEF.md
# CCD Line Blanking Sequencer

This block generates the control waveforms that a frame-transfer CCD needs during the horizontal blanking interval of each line. It runs from the pixel clock (about 36 MHz) and keeps a position counter that covers one line of 1152 counts. Each output is a decode of that count over a fixed window. The outputs are:

- a single charge-pump cycle on the four image-section phases;
- one storage-section line shift into the output register;
- a run enable for the horizontal register clocks, held low while the vertical transfers happen;
- the pre-blank, black-clamp, composite-blank and charge-reset strobes.

The counter wraps by itself at the end of the line. A line-start strobe restarts it at zero. The shutter flag is sampled once, at the start of each line. When the sampled flag is set, the line carries a charge-reset pulse inside the blanking interval, which shortens the integration time. When it is clear, no charge-reset pulse occurs on that line. Every output comes from a flop, so decode glitches cannot reach the phase lines.

Top module: `ccd_line_seq`

## Requirements
- R1: The count runs 0 to 1151 and then returns to 0. A high on line_start_i puts the count at 0 on the next edge. Each output shows the decode of the count from one cycle earlier.
- R2: hreg_run_o is low for counts 0..71 and high for all other counts.
- R3: The image phases are bit 0 = phase 1 through bit 3 = phase 4. Outside the pump they rest at 4'b0011. Bit 0 is low for counts 19..63. Bit 1 is low for counts 28..54. Bit 2 is high for counts 37..45. Bit 3 is high for counts 46..63.
- R4: The storage phases use the same bit order and rest low. Bit 0 is high for 20..49. Bit 1 is high for 32..61. Bit 2 is high for 26..43. Bit 3 is high for 38..55. No two storage edges fall in the same cycle.
- R5: On a shuttered line, charge_rst_o is high for counts 19..63. That is 45 counts, which is no shorter than the 44-count minimum pulse.
- R6: shutter_en_i is sampled only on the edge where the count goes to 0. A change in the middle of a line has no effect on that line. When the sampled value is 0, charge_rst_o stays low for the whole line.
- R7: pre_blank_o and clamp_o are both high for counts 0..79 and low for all other counts.
- R8: comp_blank_o is high for counts 1131..1151 and 0..99, across the wrap, and low for all other counts.
- R9: While rst_ni is low, the image phases are 4'b0011 and the storage phases are 0. hreg_run_o is 1 and every strobe is 0. The first line after reset is not shuttered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | Restarts the line count at zero |
| shutter_en_i | input | 1 | Requests a charge-reset pulse on the next line |
| img_ph_o | output | 4 | Image-section phase levels |
| stg_ph_o | output | 4 | Storage-section phase levels |
| hreg_run_o | output | 1 | Horizontal register clock enable |
| pre_blank_o | output | 1 | Pre-blanking strobe |
| clamp_o | output | 1 | Black-level clamp strobe |
| comp_blank_o | output | 1 | Composite blanking strobe |
| charge_rst_o | output | 1 | Charge-reset (shutter) strobe |

## Verification
The minimum-width check on the charge-reset pulse and the check that the image phases are at rest outside the pump both assume that line_start_i arrives only outside the blanking window (counts 0..99). A restart inside that window would cut the pulses short on purpose. The stimulus raises line_start_i only at count 600 or at the final count 1151, which is the same moment as the natural wrap. The shutter flag is changed freely in the middle of a line, because the design only samples it at the line boundary.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;
  localparam int unsigned NPH = 4;
  // image-section pump windows [on, off), rest level per phase
  localparam int unsigned IMG_ON  [NPH] = '{19, 28, 37, 46};
  localparam int unsigned IMG_OFF [NPH] = '{64, 55, 46, 64};
  localparam bit          IMG_IDLE[NPH] = '{1'b1, 1'b1, 1'b0, 1'b0};
  // storage-section line shift windows, rest low
  localparam int unsigned STG_ON  [NPH] = '{20, 32, 26, 38};
  localparam int unsigned STG_OFF [NPH] = '{50, 62, 44, 56};
endpackage

// File: rtl/ccd_line_cnt.sv
module ccd_line_cnt #(
  parameter int unsigned LINE_LEN = 1152,
  localparam int unsigned CNT_W   = $clog2(LINE_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LINE_LEN - 1);

  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = restart_i | (cnt_q == LAST);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ccd_win.sv
// Registered window decode: q = IDLE outside [START,STOP), inverted inside.
// START > STOP selects a window that wraps through count 0.
module ccd_win #(
  parameter int unsigned CNT_W = 11,
  parameter int unsigned START = 0,
  parameter int unsigned STOP  = 1,
  parameter bit          IDLE  = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             gate_i,
  output logic             q_o
);
  localparam logic [CNT_W-1:0] S = CNT_W'(START);
  localparam logic [CNT_W-1:0] E = CNT_W'(STOP);

  logic hit;

  generate
    if (START == 0) begin : g_from_zero
      assign hit = (cnt_i < E);
    end else if (START > STOP) begin : g_wrap
      assign hit = (cnt_i >= S) || (cnt_i < E);
    end else begin : g_plain
      assign hit = (cnt_i >= S) && (cnt_i < E);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= IDLE;
    else         q_o <= IDLE ^ (hit & gate_i);
  end
endmodule

// File: rtl/ccd_line_seq.sv
module ccd_line_seq
  import ccd_seq_pkg::*;
#(
  parameter int unsigned LINE_LEN  = 1152,
  parameter int unsigned HSTOP_END = 72,
  parameter int unsigned PB_END    = 80,
  parameter int unsigned CLAMP_END = 80,
  parameter int unsigned CB_START  = 1131,
  parameter int unsigned CB_END    = 100,
  parameter int unsigned CR_START  = 19,
  parameter int unsigned CR_END    = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_start_i,
  input  logic       shutter_en_i,
  output logic [3:0] img_ph_o,
  output logic [3:0] stg_ph_o,
  output logic       hreg_run_o,
  output logic       pre_blank_o,
  output logic       clamp_o,
  output logic       comp_blank_o,
  output logic       charge_rst_o
);
  localparam int unsigned CNT_W = $clog2(LINE_LEN);

  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic             shut_q;

  ccd_line_cnt #(.LINE_LEN(LINE_LEN)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(line_start_i),
    .cnt_o    (cnt),
    .wrap_o   (wrap)
  );

  // shutter request latched once per line, at the count-zero boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   shut_q <= 1'b0;
    else if (wrap) shut_q <= shutter_en_i;
  end

  for (genvar g = 0; g < NPH; g++) begin : g_img
    ccd_win #(.CNT_W(CNT_W), .START(IMG_ON[g]), .STOP(IMG_OFF[g]), .IDLE(IMG_IDLE[g])) u_w (
      .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(cnt), .gate_i(1'b1), .q_o(img_ph_o[g])
    );
  end

  for (genvar g = 0; g < NPH; g++) begin : g_stg
    ccd_win #(.CNT_W(CNT_W), .START(STG_ON[g]), .STOP(STG_OFF[g]), .IDLE(1'b0)) u_w (
      .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(cnt), .gate_i(1'b1), .q_o(stg_ph_o[g])
    );
  end

  ccd_win #(.CNT_W(CNT_W), .START(0), .STOP(HSTOP_END), .IDLE(1'b1)) u_hreg (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(cnt), .gate_i(1'b1), .q_o(hreg_run_o)
  );

  ccd_win #(.CNT_W(CNT_W), .START(0), .STOP(PB_END), .IDLE(1'b0)) u_pb (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(cnt), .gate_i(1'b1), .q_o(pre_blank_o)
  );

  ccd_win #(.CNT_W(CNT_W), .START(0), .STOP(CLAMP_END), .IDLE(1'b0)) u_clamp (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(cnt), .gate_i(1'b1), .q_o(clamp_o)
  );

  ccd_win #(.CNT_W(CNT_W), .START(CB_START), .STOP(CB_END), .IDLE(1'b0)) u_cb (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(cnt), .gate_i(1'b1), .q_o(comp_blank_o)
  );

  ccd_win #(.CNT_W(CNT_W), .START(CR_START), .STOP(CR_END), .IDLE(1'b0)) u_cr (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(cnt), .gate_i(shut_q), .q_o(charge_rst_o)
  );
endmodule

// File: rtl/ccd_line_seq_chk.sv
module ccd_line_seq_chk #(
  parameter int unsigned LINE_LEN = 1152,
  parameter int unsigned MIN_CR   = 44,
  localparam int unsigned CNT_W   = $clog2(LINE_LEN)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             line_start_i,
  input logic [CNT_W-1:0] cnt,
  input logic             shut_q,
  input logic [3:0]       img_ph_o,
  input logic [3:0]       stg_ph_o,
  input logic             hreg_run_o,
  input logic             pre_blank_o,
  input logic             comp_blank_o,
  input logic             charge_rst_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LINE_LEN - 1);

  logic [15:0] cr_run;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cr_run <= '0;
    else if (charge_rst_o) cr_run <= cr_run + 1'b1;
    else                   cr_run <= '0;
  end

  a_r1_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == LAST) |=> (cnt == '0));
  a_r1_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i |=> (cnt == '0));
  a_r4_stg_in_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|stg_ph_o) |-> !hreg_run_o);
  a_r4_stg_one_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(stg_ph_o ^ $past(stg_ph_o)) <= 1);
  a_r3_img_rest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hreg_run_o |-> (img_ph_o == 4'b0011));
  a_r5_cr_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(charge_rst_o) |-> (cr_run >= 16'(MIN_CR)));
  a_r6_cr_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shut_q |=> !charge_rst_o);
  a_r8_cb_covers_pb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_blank_o |-> comp_blank_o);
endmodule

bind ccd_line_seq ccd_line_seq_chk #(.LINE_LEN(LINE_LEN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .line_start_i(line_start_i),
  .cnt         (cnt),
  .shut_q      (shut_q),
  .img_ph_o    (img_ph_o),
  .stg_ph_o    (stg_ph_o),
  .hreg_run_o  (hreg_run_o),
  .pre_blank_o (pre_blank_o),
  .comp_blank_o(comp_blank_o),
  .charge_rst_o(charge_rst_o)
);

// File: tb/tb_ccd_line_seq.sv
`timescale 1ns/1ps
module tb_ccd_line_seq;
  localparam int LAST = 1151;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic line_start_i = 1'b0;
  logic shutter_en_i = 1'b0;
  logic [3:0] img_ph_o, stg_ph_o;
  logic hreg_run_o, pre_blank_o, clamp_o, comp_blank_o, charge_rst_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  ccd_line_seq dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_start_i(line_start_i),
    .shutter_en_i(shutter_en_i), .img_ph_o(img_ph_o), .stg_ph_o(stg_ph_o),
    .hreg_run_o(hreg_run_o), .pre_blank_o(pre_blank_o), .clamp_o(clamp_o),
    .comp_blank_o(comp_blank_o), .charge_rst_o(charge_rst_o)
  );

  // reference model state
  int mcnt = 0;
  bit mshut = 0;
  logic [3:0] e_img = 4'b0011, e_stg = 4'b0000;
  logic e_hreg = 1, e_pb = 0, e_cl = 0, e_cb = 0, e_cr = 0;

  function automatic bit in_rng(int c, int lo, int hi);
    return (c >= lo) && (c <= hi);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcnt = 0; mshut = 0;
      e_img = 4'b0011; e_stg = 4'b0000;
      e_hreg = 1; e_pb = 0; e_cl = 0; e_cb = 0; e_cr = 0;
    end else begin
      e_img[0] = !in_rng(mcnt, 19, 63);
      e_img[1] = !in_rng(mcnt, 28, 54);
      e_img[2] = in_rng(mcnt, 37, 45);
      e_img[3] = in_rng(mcnt, 46, 63);
      e_stg[0] = in_rng(mcnt, 20, 49);
      e_stg[1] = in_rng(mcnt, 32, 61);
      e_stg[2] = in_rng(mcnt, 26, 43);
      e_stg[3] = in_rng(mcnt, 38, 55);
      e_hreg = (mcnt >= 72);
      e_pb = (mcnt <= 79);
      e_cl = (mcnt <= 79);
      e_cb = (mcnt >= 1131) || (mcnt <= 99);
      e_cr = mshut && in_rng(mcnt, 19, 63);
      if (line_start_i || mcnt == LAST) begin
        mshut = shutter_en_i;
        mcnt = 0;
      end else begin
        mcnt = mcnt + 1;
      end
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk("R3", "img", int'(img_ph_o), int'(e_img));
      chk("R4", "stg", int'(stg_ph_o), int'(e_stg));
      chk("R2", "hreg", int'(hreg_run_o), int'(e_hreg));
      chk("R7", "pre_blank", int'(pre_blank_o), int'(e_pb));
      chk("R7", "clamp", int'(clamp_o), int'(e_cl));
      chk("R8", "comp_blank", int'(comp_blank_o), int'(e_cb));
      if (mshut || e_cr) chk("R5", "charge_rst", int'(charge_rst_o), int'(e_cr));
      else               chk("R6", "charge_rst", int'(charge_rst_o), int'(e_cr));
    end
  end

  task automatic wait_cnt(input int c);
    do @(negedge clk_i); while (mcnt != c);
  endtask

  task automatic pulse_start_check;
    line_start_i = 1'b1;
    @(negedge clk_i);
    line_start_i = 1'b0;
    @(negedge clk_i);
    // count 0 decode now on outputs
    chk("R1", "restart pre_blank", int'(pre_blank_o), 1);
    chk("R1", "restart hreg", int'(hreg_run_o), 0);
  endtask

  initial begin
    shutter_en_i = 1'b1;
    repeat (3) @(negedge clk_i);
    // R9 reset values
    chk("R9", "rst img", int'(img_ph_o), 4'b0011);
    chk("R9", "rst stg", int'(stg_ph_o), 0);
    chk("R9", "rst hreg", int'(hreg_run_o), 1);
    chk("R9", "rst strobes", int'({pre_blank_o, clamp_o, comp_blank_o, charge_rst_o}), 0);
    rst_ni = 1'b1;
    // first line unshuttered despite flag high (R9/R6)
    wait_cnt(600);
    pulse_start_check();          // restart mid-line, shuttered line follows
    wait_cnt(30);
    shutter_en_i = 1'b0;          // mid-line change ignored (R6)
    wait_cnt(500);
    wait_cnt(LAST);               // natural wrap latches 0: unshuttered line
    wait_cnt(500);
    shutter_en_i = 1'b1;
    wait_cnt(LAST);
    pulse_start_check();          // restart coincident with last count (R1)
    wait_cnt(LAST);               // another full shuttered line
    wait_cnt(200);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule